// File: doc/BRIEF.md
# Bitmap-Compressed DFA Byte Stepper

This block advances one deterministic automaton by one byte at a time. Each automaton state lives in a local 32-bit word memory as a compressed record. Only the transitions that differ from the state's fallback are stored explicitly. A coarse 32-bit summary bitmap and a fine 256-bit bitmap record which bytes have an explicit entry. The fine bitmap is spread over eight words.

For each input byte the engine makes four memory reads, always in the same order. The first is the record header. The second is the one fine-bitmap word covering the byte. The third is a word of per-word prefix counts. The fourth is either the selected packed transition or the fallback transition. The slot of an explicit transition within the packed list comes from a population count: the prefix count stored for the byte's fine-bitmap word, plus the set bits below the byte inside that word. No search is involved. The next state and an accept flag come from the transition word that was read. An accept raises the match output for one cycle.

Software or a loader fills the record memory through a plain write port while the engine is idle. A state is identified by the address of its record, and reset puts the engine in a parameterised start state.

Top module: `dfa_bitmap_engine`

## Requirements
- R1: After reset, `state_o` equals `START_ADDR`, `match_o` is 0 and `in_ready` is 1.
- R2: A write with `ld_we` high stores `ld_data` at `ld_addr`. Later lookups use the stored word.
- R3: The record at base address S is laid out as follows. Word S+0 is the summary bitmap, where bit g covers bytes 8g to 8g+7. Words S+1 to S+8 hold the fine bitmap: byte b is bit b%32 of word S+1+b/32. Word S+9 is the fallback transition. Words S+10 and S+11 hold 8-bit prefix counts: lane w%4 (bits 8*(w%4)+7 down to 8*(w%4)) of word S+10+w/4 holds the number of set fine bits in words below w. The packed list starts at S+12.
- R4: When both the summary bit and the fine bit of byte b are set, the engine reads list slot S+12+k. Here k is the prefix count of b's fine-bitmap word plus the number of set bits below position b%32 in that word.
- R5: When the summary bit of b's group is clear, the fallback transition is used, even if the fine bit of b is set.
- R6: When the fine bit of b is clear, the fallback transition at S+9 is used.
- R7: In a transition word, bits ADDR_W-1 to 0 give the next state address and bit 31 is the accept flag. `match_o` shows the accept flag for exactly one cycle, in the cycle the new state appears.
- R8: After a byte is accepted, `in_ready` stays low for exactly 4 cycles and rises in the 5th, whatever the byte and whether the lookup hits or misses.
- R9: `in_valid` and `in_byte` are ignored while `in_ready` is low. The byte that was accepted alone decides the next state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_we | input | 1 | Record memory write enable |
| ld_addr | input | ADDR_W | Record memory write address |
| ld_data | input | 32 | Record memory write data |
| in_valid | input | 1 | Input byte is present |
| in_byte | input | 8 | Input byte |
| in_ready | output | 1 | Engine can take a byte this cycle |
| match_o | output | 1 | Accept flag of the transition just taken (one cycle) |
| state_o | output | ADDR_W | Current state (record base address) |

## Verification
The assertions check the cycle-level contract on every cycle. The busy window after an accepted byte is exactly four cycles, ready returns on the fifth, the state holds still while busy and while idle, and the match pulse lasts one cycle and only in a ready cycle. Only the bench scenarios can show that the right transition is chosen. They sweep every byte value over two transition densities, check packed-slot ranks and fallback choices, check a summary bit that masks fine bits, check junk input during busy cycles, and check a two-state chain that feeds the new state back into the next lookup.

// File: rtl/dfabm_pkg.sv
package dfabm_pkg;
   localparam int WORD_W   = 32;
   localparam int HDR_OFS  = 0;
   localparam int FINE_OFS = 1;
   localparam int DFLT_OFS = 9;
   localparam int PFX_OFS  = 10;
   localparam int LIST_OFS = 12;
   localparam int ACC_BIT  = 31;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_FINE = 3'd1,
      PH_PFX  = 3'd2,
      PH_TR   = 3'd3,
      PH_UPD  = 3'd4
   } phase_t;
endpackage

// File: rtl/dfabm_store.sv
module dfabm_store #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
      rdata <= cells[raddr];
   end
endmodule

// File: rtl/dfabm_rank.sv
module dfabm_rank #(
   parameter int STYLE = 1
) (
   input  logic [31:0] word_i,
   input  logic [4:0]  pos_i,
   output logic        bit_o,
   output logic [5:0]  rank_o
);
   logic [31:0] below;

   always_comb begin
      below = word_i & ((32'd1 << pos_i) - 32'd1);
      bit_o = word_i[pos_i];
   end

   generate
      if (STYLE == 0) begin : g_flat
         always_comb begin
            rank_o = '0;
            for (int i = 0; i < 32; i++) rank_o = rank_o + 6'(below[i]);
         end
      end else begin : g_split
         logic [3:0] lane_cnt [4];
         for (genvar l = 0; l < 4; l++) begin : g_lane
            always_comb begin
               lane_cnt[l] = '0;
               for (int i = 0; i < 8; i++)
                  lane_cnt[l] = lane_cnt[l] + 4'(below[8*l+i]);
            end
         end
         always_comb
            rank_o = (6'(lane_cnt[0]) + 6'(lane_cnt[1]))
                   + (6'(lane_cnt[2]) + 6'(lane_cnt[3]));
      end
   endgenerate
endmodule

// File: rtl/dfa_bitmap_engine.sv
module dfa_bitmap_engine
   import dfabm_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int START_ADDR = 0,
   parameter int RANK_STYLE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_we,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [31:0]       ld_data,
   input  logic              in_valid,
   input  logic [7:0]        in_byte,
   output logic              in_ready,
   output logic              match_o,
   output logic [ADDR_W-1:0] state_o
);
   localparam logic [ADDR_W-1:0] START_A = ADDR_W'(START_ADDR);

   generate
      if (ADDR_W < 9 || ADDR_W > 24) begin : g_bad_addr
         $error("ADDR_W must lie in 9..24");
      end
      if (RANK_STYLE < 0 || RANK_STYLE > 1) begin : g_bad_style
         $error("RANK_STYLE must be 0 or 1");
      end
      if (START_ADDR < 0 || START_ADDR >= (1 << ADDR_W)) begin : g_bad_start
         $error("START_ADDR outside record memory");
      end
   endgenerate

   phase_t            phase_q;
   logic [ADDR_W-1:0] state_q;
   logic [7:0]        byte_q;
   logic              sum_bit_q;
   logic              hit_q;
   logic [5:0]        rank_q;
   logic              match_q;

   logic [ADDR_W-1:0] raddr;
   logic [WORD_W-1:0] rdata;
   logic              fine_bit;
   logic [5:0]        fine_rank;
   logic [7:0]        pfx_cnt;

   dfabm_store #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_store (
      .clk   (clk),
      .we    (ld_we),
      .waddr (ld_addr),
      .wdata (ld_data),
      .raddr (raddr),
      .rdata (rdata)
   );

   dfabm_rank #(.STYLE(RANK_STYLE)) u_rank (
      .word_i (rdata),
      .pos_i  (byte_q[4:0]),
      .bit_o  (fine_bit),
      .rank_o (fine_rank)
   );

   assign pfx_cnt = rdata[{byte_q[6:5], 3'b000} +: 8];

   always_comb begin
      unique case (phase_q)
         PH_IDLE: raddr = state_q + ADDR_W'(HDR_OFS);
         PH_FINE: raddr = state_q + ADDR_W'(FINE_OFS) + ADDR_W'(byte_q[7:5]);
         PH_PFX:  raddr = state_q + ADDR_W'(PFX_OFS) + ADDR_W'(byte_q[7]);
         PH_TR:   raddr = hit_q ? state_q + ADDR_W'(LIST_OFS) + ADDR_W'(pfx_cnt)
                                   + ADDR_W'(rank_q)
                                : state_q + ADDR_W'(DFLT_OFS);
         default: raddr = state_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         state_q   <= START_A;
         byte_q    <= '0;
         sum_bit_q <= 1'b0;
         hit_q     <= 1'b0;
         rank_q    <= '0;
         match_q   <= 1'b0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               match_q <= 1'b0;
               if (in_valid) begin
                  byte_q  <= in_byte;
                  phase_q <= PH_FINE;
               end
            end
            PH_FINE: begin
               sum_bit_q <= rdata[byte_q[7:3]];
               phase_q   <= PH_PFX;
            end
            PH_PFX: begin
               hit_q   <= sum_bit_q & fine_bit;
               rank_q  <= fine_rank;
               phase_q <= PH_TR;
            end
            PH_TR: phase_q <= PH_UPD;
            default: begin
               state_q <= rdata[ADDR_W-1:0];
               match_q <= rdata[ACC_BIT];
               phase_q <= PH_IDLE;
            end
         endcase
      end
   end

   assign in_ready = (phase_q == PH_IDLE);
   assign match_o  = match_q;
   assign state_o  = state_q;
endmodule

// File: rtl/dfabm_checker.sv
module dfabm_checker #(
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              match_o,
   input logic [ADDR_W-1:0] state_o
);
   a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   a_r8_still_busy_fourth: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |-> ##4 !in_ready);

   a_r8_ready_on_fifth: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |-> ##5 in_ready);

   a_r7_match_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      match_o |=> !match_o);

   a_r7_match_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
      match_o |-> in_ready);

   a_r9_state_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |=> (in_ready || $stable(state_o)));

   a_r1_state_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !in_valid) |=> $stable(state_o));
endmodule

bind dfa_bitmap_engine dfabm_checker #(.ADDR_W(ADDR_W)) u_dfabm_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .match_o  (match_o),
   .state_o  (state_o)
);

// File: tb/dfa_bitmap_engine_test.sv
module dfa_bitmap_engine_test;
   localparam int AW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_we = 1'b0;
   logic [AW-1:0] ld_addr = '0;
   logic [31:0]   ld_data = '0;
   logic          in_valid = 1'b0;
   logic [7:0]    in_byte = '0;
   logic          in_ready;
   logic          match_o;
   logic [AW-1:0] state_o;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 0;

   bit  expl [256];
   int  rank_of [256];
   logic [31:0] sum_w;

   always #10 clk = ~clk;

   dfa_bitmap_engine #(.ADDR_W(AW), .START_ADDR(0), .RANK_STYLE(1)) uut (
      .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
      .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
      .match_o(match_o), .state_o(state_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      ld_we = 1'b1; ld_addr = AW'(a); ld_data = d;
      @(negedge clk);
      ld_we = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   function automatic bit pat(input int p, input int b);
      if (p == 0) return ((b * 37 + 11) % 5) == 0;
      return (b % 3 == 1) || (b >= 240);
   endfunction

   // R2, R3: build a record at base 0 for pattern p, computed from the layout
   task automatic load_pat(input int p, input logic [31:0] dflt);
      logic [31:0] fine [8];
      int pre [8];
      int k;
      sum_w = '0;
      k = 0;
      for (int w = 0; w < 8; w++) begin
         fine[w] = '0;
         pre[w] = k;
         for (int i = 0; i < 32; i++) begin
            int b;
            b = 32 * w + i;
            expl[b] = pat(p, b);
            rank_of[b] = k;
            if (expl[b]) begin
               fine[w][i] = 1'b1;
               sum_w[b / 8] = 1'b1;
               k++;
            end
         end
      end
      wr(0, sum_w);
      for (int w = 0; w < 8; w++) wr(1 + w, fine[w]);
      wr(9, dflt);
      wr(10, {8'(pre[3]), 8'(pre[2]), 8'(pre[1]), 8'(pre[0])});
      wr(11, {8'(pre[7]), 8'(pre[6]), 8'(pre[5]), 8'(pre[4])});
      for (int b = 0; b < 256; b++)
         if (expl[b]) wr(12 + rank_of[b], {rank_of[b][0], 21'd0, 10'(200 + rank_of[b])});
   endtask

   // send one byte; optional junk on the inputs while busy; returns busy cycles
   task automatic send(input logic [7:0] b, input bit junk, output int busy);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_byte = b;
      @(negedge clk);
      busy = 0;
      while (!in_ready && busy < 20) begin
         busy++;
         if (junk && busy <= 3) begin
            in_valid = 1'b1; in_byte = ~b;
         end else begin
            in_valid = 1'b0;
         end
         @(negedge clk);
      end
      in_valid = 1'b0;
   endtask

   task automatic sweep(input int p, input int dnext, input bit dacc, input int masked_grp,
                        input bit junk);
      int busy;
      int en, ea;
      bit use_expl;
      for (int b = 0; b < 256; b++) begin
         do_reset();
         if (b == 0) begin
            check("R1 state after reset", int'(state_o), 0);
            check("R1 match after reset", int'(match_o), 0);
            check("R1 ready after reset", int'(in_ready), 1);
         end
         send(8'(b), junk, busy);
         check("R8 busy cycles", busy, 4);
         use_expl = expl[b] && (b / 8 != masked_grp);
         if (use_expl) begin
            en = 200 + rank_of[b]; ea = rank_of[b] % 2;
         end else begin
            en = dnext; ea = int'(dacc);
         end
         if (use_expl)
            check(junk ? "R4 R9 explicit slot state" : "R4 explicit slot state",
                  int'(state_o), en);
         else if (expl[b])
            check("R5 masked group uses fallback", int'(state_o), en);
         else
            check(junk ? "R6 R9 fallback state" : "R6 fallback state", int'(state_o), en);
         check("R7 accept flag", int'(match_o), ea);
         @(negedge clk);
         check("R7 match single cycle", int'(match_o), 0);
      end
   endtask

   initial begin
      int busy;
      int b_def, b_exp;
      do_reset();
      // sparse pattern, fallback without accept
      load_pat(0, {1'b0, 21'd0, 10'd77});
      sweep(0, 77, 1'b0, -1, 1'b0);
      // dense pattern, fallback with accept, summary group 3 cleared, junk while busy
      load_pat(1, {1'b1, 21'd0, 10'd700});
      wr(0, sum_w & ~32'h8);
      sweep(1, 700, 1'b1, 3, 1'b1);
      // record at 700: no explicit entries, fallback back to 0
      for (int i = 0; i < 12; i++) wr(700 + i, (i == 9) ? 32'd0 : 32'd0);
      do_reset();
      b_def = 0;  // byte 0: 0 % 3 != 1, below 240, so no explicit entry
      b_exp = 4;  // byte 4: 4 % 3 == 1, group 0, explicit
      send(8'(b_def), 1'b0, busy);
      check("R2 R6 chain step to 700", int'(state_o), 700);
      check("R7 chain accept", int'(match_o), 1);
      send(8'(b_exp), 1'b0, busy);
      check("R6 chain back to start", int'(state_o), 0);
      check("R7 chain no accept", int'(match_o), 0);
      send(8'(b_exp), 1'b0, busy);
      check("R4 chain explicit from start", int'(state_o), 200 + rank_of[b_exp]);
      check("R8 chain busy", busy, 4);
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule